// File: doc/BRIEF.md
# Auxiliary-Switched Dual Register Peripheral

This block is one peripheral on a narrow 4-bit I/O bus. Each bus cycle carries a 4-bit module address, a 4-bit data nibble, a write strobe and a read strobe. The block answers to its own module address. A plain write or read at that address reaches a nibble-wide primary register. A second, separate address on the same bus belongs to an auxiliary switch. Writing this block's address as data to the switch arms the block. The next transfers to this block then go to a byte-wide auxiliary register instead of the primary one.

The auxiliary register is wider than the bus, so it moves as consecutive nibble transfers to the same address, low nibble first. A write of the low nibble goes to a staging latch. The auxiliary register changes in one step when the high nibble arrives. After the last nibble the block drops back to primary access by itself. A switch command that names any other module cancels a pending selection. Read data is driven in the same cycle as the read strobe, together with an enable.

Top module: `aux_dual_reg`

## Requirements
- R1: A synchronous active-high reset clears the primary register and the auxiliary register to zero and leaves the block unarmed with the nibble phase at the low nibble.
- R2: With the block unarmed, a write strobe at the module address loads the write nibble into the primary register and leaves the auxiliary register unchanged.
- R3: With the block unarmed, a read strobe at the module address drives the primary register on the read data in the same cycle with the read enable high, and changes no state.
- R4: A write to the switch address whose data equals the module address arms the block, so the next access at the module address goes to the auxiliary register.
- R5: An armed write of the low nibble (auxiliary bits 3:0) leaves the auxiliary register output unchanged. The following write of the high nibble (bits 7:4) updates all eight bits in the same clock edge.
- R6: Once the high nibble has been written or read, the block is unarmed again, and later accesses reach the primary register.
- R7: An armed read returns auxiliary bits 3:0 on the first read strobe and bits 7:4 on the second read strobe.
- R8: A write to the switch address whose data differs from the module address disarms the block and returns the phase to the low nibble.
- R9: Strobes at any address other than the module address leave the read enable low and the read data at zero. Apart from the switch commands of R4 and R8, they change no register.
- R10: When both strobes are high in one cycle, the access is taken as a write and the read enable stays low.
- R11: A switch command that names this module while a transfer is partly done restarts the transfer at the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 4 | Module address of the current bus cycle |
| io_wdata | input | 4 | Write data nibble |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 4 | Read data nibble, zero when not driven |
| io_rdata_en | output | 1 | High while this block drives read data |
| prim_q | output | 4 | Primary register to the peripheral function |
| aux_q | output | 8 | Auxiliary register to the peripheral function |

## Verification
The hardest states to reach are the interrupted ones: an armed transfer with one nibble done that is then cut off by a switch command to another module, re-armed by a command to this module, mixed with reads, or hit by both strobes at once. Directed sequences build each of these cases on purpose. A long random run then weights the addresses toward the module and switch addresses, and the switch data toward this module's own address, so that half-finished transfers keep being interrupted in all of these ways.

// File: rtl/adr_pkg.sv
package adr_pkg;
    localparam int BUS_AW = 4;
    localparam int BUS_DW = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PRIM_WR,
        OP_PRIM_RD,
        OP_AUX_WR,
        OP_AUX_RD,
        OP_SW_SELF,
        OP_SW_OTHER
    } op_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
        logic              wr;
        logic              rd;
    } bus_req_t;

    function automatic op_e classify(bus_req_t r, logic [BUS_AW-1:0] mod_a,
                                     logic [BUS_AW-1:0] sw_a, logic armed);
        op_e o;
        o = OP_NONE;
        if (r.wr) begin
            if (r.addr == sw_a)
                o = (r.data == mod_a) ? OP_SW_SELF : OP_SW_OTHER;
            else if (r.addr == mod_a)
                o = armed ? OP_AUX_WR : OP_PRIM_WR;
        end else if (r.rd && r.addr == mod_a) begin
            o = armed ? OP_AUX_RD : OP_PRIM_RD;
        end
        return o;
    endfunction

    function automatic logic is_read(op_e o);
        return (o == OP_PRIM_RD) || (o == OP_AUX_RD);
    endfunction
endpackage

// File: rtl/adr_decode.sv
module adr_decode
    import adr_pkg::*;
#(
    parameter logic [BUS_AW-1:0] MOD_ADDR = 4'h5,
    parameter logic [BUS_AW-1:0] SW_ADDR  = 4'hF
) (
    input  bus_req_t req,
    input  logic     armed,
    output op_e      op
);
    always_comb op = classify(req, MOD_ADDR, SW_ADDR, armed);
endmodule

// File: rtl/adr_aux_ctrl.sv
module adr_aux_ctrl
    import adr_pkg::*;
#(
    parameter int AUX_NIBBLES = 2,
    localparam int PH_W = (AUX_NIBBLES > 1) ? $clog2(AUX_NIBBLES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  op_e             op,
    output logic            armed,
    output logic [PH_W-1:0] phase,
    output logic            commit,
    output logic            stage_we
);
    localparam logic [PH_W-1:0] LAST = PH_W'(AUX_NIBBLES - 1);

    logic last;
    assign last     = (phase == LAST);
    assign commit   = (op == OP_AUX_WR) && last;
    assign stage_we = (op == OP_AUX_WR) && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            phase <= '0;
        end else begin
            unique case (op)
                OP_SW_SELF: begin
                    armed <= 1'b1;
                    phase <= '0;
                end
                OP_SW_OTHER: begin
                    armed <= 1'b0;
                    phase <= '0;
                end
                OP_AUX_WR, OP_AUX_RD: begin
                    if (last) begin
                        armed <= 1'b0;
                        phase <= '0;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_arm_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SW_SELF) |=> (armed && phase == '0));
    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SW_OTHER) |=> (!armed && phase == '0));
    assert_revert_R6: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_AUX_WR || op == OP_AUX_RD) && phase == LAST) |=> !armed);
    assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
        (armed && phase != '0 && op == OP_SW_SELF) |=> (phase == '0));
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!armed && phase == '0));
endmodule

// File: rtl/adr_regs.sv
module adr_regs
    import adr_pkg::*;
#(
    parameter int AUX_NIBBLES = 2,
    localparam int PH_W  = (AUX_NIBBLES > 1) ? $clog2(AUX_NIBBLES) : 1,
    localparam int AUX_W = AUX_NIBBLES * BUS_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [BUS_DW-1:0] wdata,
    input  logic [PH_W-1:0]   phase,
    input  logic              commit,
    input  logic              stage_we,
    output logic [BUS_DW-1:0] prim_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic [BUS_DW-1:0] rd_nib
);
    logic [AUX_NIBBLES-1:0][BUS_DW-1:0] stage;
    logic [AUX_W-1:0]                   next_aux;

    generate
        for (genvar k = 0; k < AUX_NIBBLES; k++) begin : g_nib
            if (k < AUX_NIBBLES - 1) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        stage[k] <= '0;
                    else if (stage_we && phase == PH_W'(k))
                        stage[k] <= wdata;
                end
                assign next_aux[k*BUS_DW +: BUS_DW] = stage[k];
            end else begin : g_top
                assign stage[k] = '0;
                assign next_aux[k*BUS_DW +: BUS_DW] = wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            aux_q  <= '0;
        end else begin
            if (op == OP_PRIM_WR)
                prim_q <= wdata;
            if (commit)
                aux_q <= next_aux;
        end
    end

    always_comb begin
        if (op == OP_AUX_RD)
            rd_nib = aux_q[phase*BUS_DW +: BUS_DW];
        else
            rd_nib = prim_q;
    end

    assert_atomic_R5: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(aux_q));
    assert_prim_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (op != OP_PRIM_WR) |=> $stable(prim_q));
    assert_prim_load_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PRIM_WR) |=> (prim_q == $past(wdata)));
endmodule

// File: rtl/aux_dual_reg.sv
module aux_dual_reg
    import adr_pkg::*;
#(
    parameter logic [3:0] MOD_ADDR    = 4'h5,
    parameter logic [3:0] SW_ADDR     = 4'hF,
    parameter int         AUX_NIBBLES = 2,
    localparam int PH_W  = (AUX_NIBBLES > 1) ? $clog2(AUX_NIBBLES) : 1,
    localparam int AUX_W = AUX_NIBBLES * BUS_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] io_addr,
    input  logic [BUS_DW-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [BUS_DW-1:0] io_rdata,
    output logic              io_rdata_en,
    output logic [BUS_DW-1:0] prim_q,
    output logic [AUX_W-1:0]  aux_q
);
    bus_req_t          req;
    op_e               op;
    logic              armed;
    logic [PH_W-1:0]   phase;
    logic              commit;
    logic              stage_we;
    logic [BUS_DW-1:0] rd_nib;

    assign req = '{addr: io_addr, data: io_wdata, wr: io_wr, rd: io_rd};

    adr_decode #(.MOD_ADDR(MOD_ADDR), .SW_ADDR(SW_ADDR)) u_decode (
        .req   (req),
        .armed (armed),
        .op    (op)
    );

    adr_aux_ctrl #(.AUX_NIBBLES(AUX_NIBBLES)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .armed    (armed),
        .phase    (phase),
        .commit   (commit),
        .stage_we (stage_we)
    );

    adr_regs #(.AUX_NIBBLES(AUX_NIBBLES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (io_wdata),
        .phase    (phase),
        .commit   (commit),
        .stage_we (stage_we),
        .prim_q   (prim_q),
        .aux_q    (aux_q),
        .rd_nib   (rd_nib)
    );

    assign io_rdata_en = is_read(op);
    assign io_rdata    = io_rdata_en ? rd_nib : '0;

    assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (io_addr != MOD_ADDR) |-> (!io_rdata_en && io_rdata == '0));
    assert_wr_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_rd) |-> !io_rdata_en);
    assert_rd_en_R3: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && io_addr == MOD_ADDR) |-> io_rdata_en);
    assert_reset_regs_R1: assert property (@(posedge clk)
        rst |=> (prim_q == '0 && aux_q == '0));
endmodule

// File: tb/aux_dual_reg_bench.sv
module aux_dual_reg_bench;
    localparam int CLK_P = 10;
    localparam logic [3:0] MOD = 4'h5;
    localparam logic [3:0] SW  = 4'hF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] io_addr = '0;
    logic [3:0] io_wdata = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [3:0] io_rdata;
    logic       io_rdata_en;
    logic [3:0] prim_q;
    logic [7:0] aux_q;

    int n_chk = 0;
    int n_bad = 0;

    logic [3:0] m_prim;
    logic [7:0] m_aux;
    logic [3:0] m_stage;
    logic       m_armed;
    logic       m_ph;

    always #(CLK_P/2) clk = ~clk;

    aux_dual_reg #(.MOD_ADDR(MOD), .SW_ADDR(SW), .AUX_NIBBLES(2)) u_aux_dual_reg (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .io_rdata_en(io_rdata_en), .prim_q(prim_q), .aux_q(aux_q)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_en(logic [3:0] a, logic w, logic r);
        return r && !w && a == MOD;
    endfunction

    function automatic logic [3:0] exp_rd(logic [3:0] a, logic w, logic r);
        if (!exp_en(a, w, r)) return 4'h0;
        if (!m_armed) return m_prim;
        return m_ph ? m_aux[7:4] : m_aux[3:0];
    endfunction

    function automatic string rd_tag(logic [3:0] a, logic w, logic r);
        if (w && r) return "R10";
        if (a != MOD) return "R9";
        if (m_armed) return "R7";
        return "R3";
    endfunction

    function automatic string st_tag(logic [3:0] a, logic w);
        if (w && a == SW) return (m_armed && m_ph) ? "R11" : "R4";
        if (w && a == MOD) return m_armed ? "R5" : "R2";
        if (a != MOD) return "R9";
        return "R6";
    endfunction

    task automatic model_reset();
        m_prim = '0; m_aux = '0; m_stage = '0; m_armed = 1'b0; m_ph = 1'b0;
    endtask

    task automatic model_step(input logic [3:0] a, d, input logic w, r);
        if (w) begin
            if (a == SW) begin
                m_armed = (d == MOD);
                m_ph = 1'b0;
            end else if (a == MOD) begin
                if (m_armed) begin
                    if (m_ph) begin
                        m_aux = {d, m_stage};
                        m_armed = 1'b0;
                        m_ph = 1'b0;
                    end else begin
                        m_stage = d;
                        m_ph = 1'b1;
                    end
                end else begin
                    m_prim = d;
                end
            end
        end else if (r && a == MOD && m_armed) begin
            if (m_ph) begin m_armed = 1'b0; m_ph = 1'b0; end
            else m_ph = 1'b1;
        end
    endtask

    task automatic step(input logic [3:0] a, d, input logic w, r);
        string tr, ts;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = w; io_rd = r;
        #(CLK_P/4);
        tr = rd_tag(a, w, r);
        ts = st_tag(a, w);
        check({tr, " rdata_en"}, {7'd0, io_rdata_en}, {7'd0, exp_en(a, w, r)});
        check({tr, " rdata"}, {4'd0, io_rdata}, {4'd0, exp_rd(a, w, r)});
        model_step(a, d, w, r);
        @(posedge clk);
        #1;
        check({ts, " prim_q"}, {4'd0, prim_q}, {4'd0, m_prim});
        check({ts, " aux_q"}, aux_q, m_aux);
        io_wr = 1'b0; io_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; io_wr = 1'b0; io_rd = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        model_reset();
        check("R1 prim_q", {4'd0, prim_q}, 8'h00);
        check("R1 aux_q", aux_q, 8'h00);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd4242);
        model_reset();
        do_reset();
        // R1: unarmed after reset, read hits primary
        step(MOD, 4'h0, 1'b0, 1'b1);
        // R2 / R3: primary write and read
        step(MOD, 4'hA, 1'b1, 1'b0);
        step(MOD, 4'h0, 1'b0, 1'b1);
        // R4 / R5 / R6: armed byte write, atomic on high nibble
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'h3, 1'b1, 1'b0);
        step(MOD, 4'hC, 1'b1, 1'b0);
        step(MOD, 4'h0, 1'b0, 1'b1);
        step(MOD, 4'h7, 1'b1, 1'b0);
        // R7: armed read low then high, then back to primary
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'h0, 1'b0, 1'b1);
        step(MOD, 4'h0, 1'b0, 1'b1);
        step(MOD, 4'h0, 1'b0, 1'b1);
        // R8: cancel after partial write
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'h9, 1'b1, 1'b0);
        step(SW, 4'h2, 1'b1, 1'b0);
        step(MOD, 4'h1, 1'b1, 1'b0);
        step(MOD, 4'h0, 1'b0, 1'b1);
        // R11: re-arm mid-transfer restarts at low nibble
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'h4, 1'b1, 1'b0);
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'hB, 1'b1, 1'b0);
        step(MOD, 4'hE, 1'b1, 1'b0);
        // R9: other address ignored; R10: both strobes
        step(4'h3, 4'h6, 1'b1, 1'b1);
        step(4'h3, 4'h6, 1'b0, 1'b1);
        step(MOD, 4'h8, 1'b1, 1'b1);
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'h2, 1'b1, 1'b1);
        step(MOD, 4'hD, 1'b1, 1'b1);
        // R1: reset while armed mid-transfer
        step(SW, MOD, 1'b1, 1'b0);
        step(MOD, 4'h5, 1'b1, 1'b0);
        do_reset();
        step(MOD, 4'h0, 1'b0, 1'b1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] a, d;
            logic w, r;
            int sel;
            sel = int'($urandom % 8);
            if (sel < 3) a = MOD;
            else if (sel < 5) a = SW;
            else a = 4'($urandom);
            d = 4'($urandom);
            if (a == SW && ($urandom % 2) == 0) d = MOD;
            sel = int'($urandom % 4);
            w = (sel == 0) || (sel == 2);
            r = (sel == 1) || (sel == 2);
            step(a, d, w, r);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule